// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software drives through a small register file on a simple synchronous bus: one enable, one write strobe, a 3-bit word address and 16-bit data. Software programs a tick count, releases a halt bit, and then has to write to a kick register before the count runs out. A free-running prescaler turns a fixed number of clock cycles into one tick, and each tick steps a down-counter.

If the count runs out, the block does not reset the system straight away. It first records a timeout in a sticky status flag. It can also pulse a management interrupt, so a handler gets the chance to recover. The counter then reloads and keeps running. If a second run-out follows with no kick in between, the block records a second-timeout flag and raises a system reset request for a fixed number of cycles. A reboot-inhibit bit can suppress this request, and a strap input can lock that bit on.

The second-timeout flag and a boot flag sit on the power-on reset only. Software can therefore still read them after the reset that the watchdog itself caused.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset the register reads are: CTRL (address 2) = 0x0800, with the halt bit set. GCTL (address 6) = 0x0020, with inhibit set. IRQEN (address 5) = 0. STS1 (address 3) = 0. STS2 (address 4) = 0x0004, with the boot flag set. TIMEOUT (address 0) = the reset parameter. Both outputs are low. A system reset on `rst_n` alone restores all of these except STS2.
- R2: In TIMEOUT, bits [9:0] hold the tick count. Bits [15:10] are stored and read back unchanged, but they play no part in the count.
- R3: A programmed count of 0 or 1 behaves as 2 ticks.
- R4: CTRL bit 11 is the halt bit. While it is 1, the counter keeps its value and the prescaler is held at zero.
- R5: CTRL bit 9 is owned by the hardware. It reads 1 from a first expiry until the next kick or second expiry, and software writes never change it. All other CTRL bits, apart from bit 11, read 0.
- R6: Any write to KICK (address 1) reloads the counter with the effective count, restarts the prescaler and clears the stage. A read of KICK returns the current count.
- R7: When the counter runs out for the first time, which is T ticks (T×PRESC cycles) after a reload or a halt release, the block sets STS1 bit 3. It reloads the counter and drives `mgmt_irq` high for exactly one cycle, but only if IRQEN bit 0 is 1.
- R8: A second run-out T ticks later, with no kick in between, sets STS2 bit 1. It also holds `sys_rst_req` high for HOLD cycles, unless inhibit is in effect, and it does not pulse `mgmt_irq`.
- R9: Status flags are cleared only by writing 1 to their bit; writing 0 leaves them as they are. A single STS2 write with bits 1 and 2 both set clears only bit 1, so the boot flag needs a write of its own.
- R10: GCTL bit 5 is reboot-inhibit, and it blocks `sys_rst_req`. While `inhibit_lock` is high, the bit reads 1 and writes of 0 are ignored.
- R11: The STS2 flags are reset only by `por_n`, so they keep their value through `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including STS2 |
| rst_n | input | 1 | System reset, active low; leaves STS2 flags intact |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the addressed register |
| inhibit_lock | input | 1 | Strap that forces reboot-inhibit on |
| mgmt_irq | output | 1 | One-cycle pulse on a first-stage timeout |
| sys_rst_req | output | 1 | System reset request, held HOLD cycles |

## Verification
A wrong count or a prescaler off by a cycle shows up as an interrupt or status bit that appears one or more cycles away from the T×PRESC mark. The bench samples these bits in the cycle just before that mark and in the cycle just after it. A stage bit stuck in the wrong state turns the first run-out into a reset request, or the second into an interrupt, within two timeout periods. A status flag in the wrong reset domain is caught by the very next read after `rst_n`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_TMO   = 3'd0,
    RA_KICK  = 3'd1,
    RA_CTRL  = 3'd2,
    RA_STS1  = 3'd3,
    RA_STS2  = 3'd4,
    RA_IRQEN = 3'd5,
    RA_GCTL  = 3'd6
  } wdt_addr_e;

  localparam int CTRL_HALT_BIT  = 11;
  localparam int CTRL_ARMED_BIT = 9;
  localparam int STS1_TO_BIT    = 3;
  localparam int STS2_SEC_BIT   = 1;
  localparam int STS2_BOOT_BIT  = 2;
  localparam int IRQEN_BIT      = 0;
  localparam int GCTL_INH_BIT   = 5;

  localparam int MIN_TICKS = 2;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;

  always_comb begin
    pcnt_en = 1'b1;
    pcnt_d  = pcnt_q;
    if (restart || !run) begin
      pcnt_d = '0;
    end else if (pcnt_q == LAST) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + PW'(1);
    end
    if (pcnt_d == pcnt_q) pcnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  assign tick = run && !restart && (pcnt_q == LAST);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int                CNT_W   = 10,
  parameter logic [CNT_W-1:0]  CNT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             first_exp,
  output logic             second_exp
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             expire;
  logic             upd_en;

  assign expire     = tick && !kick && (cnt_q == CNT_W'(1));
  assign first_exp  = expire && !armed_q;
  assign second_exp = expire && armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (kick) begin
      cnt_d   = load_val;
      armed_d = 1'b0;
    end else if (expire) begin
      cnt_d   = load_val;
      armed_d = !armed_q;
    end else if (tick) begin
      cnt_d   = cnt_q - CNT_W'(1);
    end
    upd_en = kick || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_RST;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign count = cnt_q;
  assign armed = armed_q;

endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_exp,
  input  logic second_exp,
  input  logic irq_en,
  input  logic inhibit,
  output logic irq,
  output logic rst_req
);

  localparam int HW = $clog2(HOLD + 1);

  logic          irq_q, irq_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    irq_d   = first_exp && irq_en;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (second_exp && !inhibit) begin
      hold_d  = HW'(HOLD);
      hold_en = 1'b1;
    end else if (hold_q != '0) begin
      hold_d  = hold_q - HW'(1);
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign irq     = irq_q;
  assign rst_req = (hold_q != '0);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int                CNT_W     = 10,
  parameter logic [DATA_W-1:0] TMO_RESET = 16'h0004
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inhibit_lock,
  input  logic [CNT_W-1:0]  count,
  input  logic              armed,
  input  logic              first_exp,
  input  logic              second_exp,
  output logic [DATA_W-1:0] tmo_val,
  output logic              halt,
  output logic              kick,
  output logic              irq_en,
  output logic              inhibit_eff,
  output logic              second_flag
);

  logic              wr;
  logic              wr_tmo, wr_ctrl, wr_sts1, wr_sts2, wr_irqen, wr_gctl;

  logic [DATA_W-1:0] tmo_q, tmo_d;
  logic              halt_q, halt_d;
  logic              to1_q, to1_d;
  logic              irqen_q, irqen_d;
  logic              inh_q, inh_d;
  logic              sec_q, sec_d;
  logic              boot_q, boot_d;

  assign wr       = bus_en && bus_we;
  assign wr_tmo   = wr && (bus_addr == RA_TMO);
  assign kick     = wr && (bus_addr == RA_KICK);
  assign wr_ctrl  = wr && (bus_addr == RA_CTRL);
  assign wr_sts1  = wr && (bus_addr == RA_STS1);
  assign wr_sts2  = wr && (bus_addr == RA_STS2);
  assign wr_irqen = wr && (bus_addr == RA_IRQEN);
  assign wr_gctl  = wr && (bus_addr == RA_GCTL);

  // next state, system-reset domain
  always_comb begin
    tmo_d   = wr_tmo   ? bus_wdata                : tmo_q;
    halt_d  = wr_ctrl  ? bus_wdata[CTRL_HALT_BIT] : halt_q;
    irqen_d = wr_irqen ? bus_wdata[IRQEN_BIT]     : irqen_q;
    inh_d   = (wr_gctl && !inhibit_lock) ? bus_wdata[GCTL_INH_BIT] : inh_q;
    if (first_exp) begin
      to1_d = 1'b1;
    end else if (wr_sts1 && bus_wdata[STS1_TO_BIT]) begin
      to1_d = 1'b0;
    end else begin
      to1_d = to1_q;
    end
  end

  // next state, power-on domain; a second-timeout clear takes the write
  always_comb begin
    if (second_exp) begin
      sec_d = 1'b1;
    end else if (wr_sts2 && bus_wdata[STS2_SEC_BIT]) begin
      sec_d = 1'b0;
    end else begin
      sec_d = sec_q;
    end
    if (wr_sts2 && bus_wdata[STS2_BOOT_BIT] && !bus_wdata[STS2_SEC_BIT]) begin
      boot_d = 1'b0;
    end else begin
      boot_d = boot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= TMO_RESET;
      halt_q  <= 1'b1;
      to1_q   <= 1'b0;
      irqen_q <= 1'b0;
      inh_q   <= 1'b1;
    end else begin
      tmo_q   <= tmo_d;
      halt_q  <= halt_d;
      to1_q   <= to1_d;
      irqen_q <= irqen_d;
      inh_q   <= inh_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sec_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      sec_q  <= sec_d;
      boot_q <= boot_d;
    end
  end

  assign inhibit_eff = inh_q || inhibit_lock;

  always_comb begin
    bus_rdata = '0;
    case (wdt_addr_e'(bus_addr))
      RA_TMO:   bus_rdata = tmo_q;
      RA_KICK:  bus_rdata[CNT_W-1:0] = count;
      RA_CTRL: begin
        bus_rdata[CTRL_HALT_BIT]  = halt_q;
        bus_rdata[CTRL_ARMED_BIT] = armed;
      end
      RA_STS1:  bus_rdata[STS1_TO_BIT] = to1_q;
      RA_STS2: begin
        bus_rdata[STS2_SEC_BIT]  = sec_q;
        bus_rdata[STS2_BOOT_BIT] = boot_q;
      end
      RA_IRQEN: bus_rdata[IRQEN_BIT] = irqen_q;
      RA_GCTL:  bus_rdata[GCTL_INH_BIT] = inhibit_eff;
      default:  bus_rdata = '0;
    endcase
  end

  assign tmo_val     = tmo_q;
  assign halt        = halt_q;
  assign irq_en      = irqen_q;
  assign second_flag = sec_q;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int                CNT_W     = 10,
  parameter int                PRESC     = 1000,
  parameter int                HOLD      = 16,
  parameter logic [DATA_W-1:0] TMO_RESET = 16'h0004
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inhibit_lock,
  output logic              mgmt_irq,
  output logic              sys_rst_req
);

  localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] RST_FIELD = TMO_RESET[CNT_W-1:0];
  localparam logic [CNT_W-1:0] CNT_RST   = (RST_FIELD < MIN_CNT) ? MIN_CNT : RST_FIELD;

  logic [DATA_W-1:0] tmo_w;
  logic [CNT_W-1:0]  eff_w;
  logic [CNT_W-1:0]  count_w;
  logic              halt_w, kick_w, irq_en_w, inh_eff_w, sec_flag_w;
  logic              armed_w, first_w, second_w, tick_w;

  assign eff_w = (tmo_w[CNT_W-1:0] < MIN_CNT) ? MIN_CNT : tmo_w[CNT_W-1:0];

  wdt_regs #(
    .CNT_W     (CNT_W),
    .TMO_RESET (TMO_RESET)
  ) u_regs (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .inhibit_lock (inhibit_lock),
    .count        (count_w),
    .armed        (armed_w),
    .first_exp    (first_w),
    .second_exp   (second_w),
    .tmo_val      (tmo_w),
    .halt         (halt_w),
    .kick         (kick_w),
    .irq_en       (irq_en_w),
    .inhibit_eff  (inh_eff_w),
    .second_flag  (sec_flag_w)
  );

  wdt_prescale #(
    .PRESC (PRESC)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!halt_w),
    .restart (kick_w),
    .tick    (tick_w)
  );

  wdt_countdown #(
    .CNT_W   (CNT_W),
    .CNT_RST (CNT_RST)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick       (kick_w),
    .tick       (tick_w),
    .load_val   (eff_w),
    .count      (count_w),
    .armed      (armed_w),
    .first_exp  (first_w),
    .second_exp (second_w)
  );

  wdt_alarm #(
    .HOLD (HOLD)
  ) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_exp  (first_w),
    .second_exp (second_w),
    .irq_en     (irq_en_w),
    .inhibit    (inh_eff_w),
    .irq        (mgmt_irq),
    .rst_req    (sys_rst_req)
  );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mgmt_irq,
  input logic             sys_rst_req,
  input logic             halt,
  input logic             kick,
  input logic [CNT_W-1:0] count,
  input logic             inh_eff,
  input logic             sec_flag,
  input logic             irq_en
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_irq |=> !mgmt_irq); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_irq |-> $past(irq_en)); // R7

  AST_HALT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !kick) |=> $stable(count)); // R4

  AST_KICK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count >= CNT_W'(2))); // R3

  AST_RST_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> !$past(inh_eff)); // R10

  AST_RST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> sec_flag); // R8

endmodule

bind wdt_two_stage wdt_chk #(
  .CNT_W (CNT_W)
) u_wdt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mgmt_irq    (mgmt_irq),
  .sys_rst_req (sys_rst_req),
  .halt        (halt_w),
  .kick        (kick_w),
  .count       (count_w),
  .inh_eff     (inh_eff_w),
  .sec_flag    (sec_flag_w),
  .irq_en      (irq_en_w)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;

  localparam int PRESC = 4;
  localparam int HOLD  = 5;

  localparam logic [2:0] A_TMO = 3'd0, A_KICK = 3'd1, A_CTRL = 3'd2, A_STS1 = 3'd3,
                         A_STS2 = 3'd4, A_IRQEN = 3'd5, A_GCTL = 3'd6;

  logic        clk = 1'b0;
  logic        por_n, rst_n, bus_en, bus_we, inhibit_lock;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mgmt_irq, sys_rst_req;

  always #5 clk = ~clk;

  wdt_two_stage #(
    .CNT_W (10), .PRESC (PRESC), .HOLD (HOLD), .TMO_RESET (16'h0008)
  ) dut (
    .clk (clk), .por_n (por_n), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .inhibit_lock (inhibit_lock), .mgmt_irq (mgmt_irq), .sys_rst_req (sys_rst_req)
  );

  typedef struct {
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  logic rd_live = 1'b0;
  logic done = 1'b0;

  // monitor: pops expected read items mid-cycle
  always @(negedge clk) begin
    exp_t it;
    if (rd_live) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; rd_live = 1'b1;
    @(posedge clk); #1;
    bus_en = 1'b0; rd_live = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; inhibit_lock = 1'b0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    pin(mgmt_irq, 1'b0, "R1 irq after reset");
    pin(sys_rst_req, 1'b0, "R1 rst_req after reset");
    rd(A_CTRL,  16'h0800, "R1 ctrl");
    rd(A_GCTL,  16'h0020, "R1 gctl");
    rd(A_IRQEN, 16'h0000, "R1 irqen");
    rd(A_STS1,  16'h0000, "R1 sts1");
    rd(A_STS2,  16'h0004, "R1 sts2 boot");
    rd(A_TMO,   16'h0008, "R1 timeout");

    // R2 upper bits stored, not counted
    wr(A_IRQEN, 16'h0001);
    wr(A_GCTL, 16'h0000);
    rd(A_GCTL, 16'h0000, "R10 gctl cleared");
    wr(A_TMO, 16'hFC03);
    rd(A_TMO, 16'hFC03, "R2 timeout readback");
    wr(A_KICK, 16'h0000);
    rd(A_KICK, 16'h0003, "R2 R6 count field only");
    step(20);
    rd(A_KICK, 16'h0003, "R4 halted count holds");

    // release halt (E0); bit 9 write ignored
    wr(A_CTRL, 16'h0200);
    rd(A_CTRL, 16'h0000, "R5 bit9 not writable");        // E1
    step(10);                                            // E11+1
    pin(mgmt_irq, 1'b0, "R7 irq before first expiry");
    step(1);                                             // E12+1
    pin(mgmt_irq, 1'b1, "R7 irq at first expiry");
    rd(A_STS1, 16'h0008, "R7 first-stage flag");          // E13
    pin(mgmt_irq, 1'b0, "R7 irq one cycle");
    rd(A_CTRL, 16'h0200, "R5 armed bit set");             // E14
    step(9);                                             // E23+1
    pin(sys_rst_req, 1'b0, "R8 rst_req before second expiry");
    step(1);                                             // E24+1
    pin(sys_rst_req, 1'b1, "R8 rst_req at second expiry");
    pin(mgmt_irq, 1'b0, "R8 no irq on second expiry");
    rd(A_STS2, 16'h0006, "R8 second flag");               // E25
    step(3);                                             // E28+1
    pin(sys_rst_req, 1'b1, "R8 rst_req held");
    step(1);                                             // E29+1
    pin(sys_rst_req, 1'b0, "R8 rst_req released after HOLD");
    wr(A_CTRL, 16'h0800);

    // R11 system reset keeps STS2
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    rd(A_STS2, 16'h0006, "R11 sts2 survives rst_n");
    rd(A_STS1, 16'h0000, "R1 sts1 cleared by rst_n");
    rd(A_CTRL, 16'h0800, "R1 halt after rst_n");
    rd(A_GCTL, 16'h0020, "R1 inhibit after rst_n");

    // R9 write-1-to-clear on STS2
    wr(A_STS2, 16'h0006);
    rd(A_STS2, 16'h0004, "R9 only second cleared");
    wr(A_STS2, 16'h0000);
    rd(A_STS2, 16'h0004, "R9 zero write no effect");
    wr(A_STS2, 16'h0004);
    rd(A_STS2, 16'h0000, "R9 boot cleared alone");

    // R3 minimum, R10 inhibit, irq disabled
    wr(A_TMO, 16'h0001);
    wr(A_KICK, 16'h0000);
    rd(A_KICK, 16'h0002, "R3 count floor");
    wr(A_CTRL, 16'h0000);                                // E0
    step(7);                                             // E7+1
    rd(A_STS1, 16'h0000, "R3 no expiry before 2 ticks"); // E8
    pin(mgmt_irq, 1'b0, "R7 irq masked when disabled");
    rd(A_STS1, 16'h0008, "R3 expiry at 2 ticks");         // E9
    step(6);
    step(1);                                             // E16+1
    pin(sys_rst_req, 1'b0, "R10 inhibit blocks rst_req");
    rd(A_STS2, 16'h0002, "R8 flag set while inhibited");
    wr(A_CTRL, 16'h0800);
    rd(A_CTRL, 16'h0800, "R5 stage cleared after second");
    wr(A_STS1, 16'h0000);
    rd(A_STS1, 16'h0008, "R9 sts1 zero write");
    wr(A_STS1, 16'h0008);
    rd(A_STS1, 16'h0000, "R9 sts1 cleared");

    // R6 kick postpones expiry
    wr(A_TMO, 16'h0003);
    wr(A_KICK, 16'h0000);
    wr(A_CTRL, 16'h0000);                                // E0
    step(10);                                            // E10+1
    wr(A_KICK, 16'h0000);                                // E11
    rd(A_KICK, 16'h0003, "R6 kick reload");               // E12
    step(10);                                            // E22+1
    rd(A_STS1, 16'h0000, "R6 no expiry before new period"); // E23
    rd(A_STS1, 16'h0008, "R6 expiry one period after kick");
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, 16'h0A00, "R5 other ctrl bits read zero");

    // R10 lock
    wr(A_GCTL, 16'h0020);
    rd(A_GCTL, 16'h0020, "R10 inhibit set");
    wr(A_GCTL, 16'h0000);
    rd(A_GCTL, 16'h0000, "R10 inhibit cleared");
    inhibit_lock = 1'b1;
    rd(A_GCTL, 16'h0020, "R10 lock forces read 1");
    wr(A_GCTL, 16'h0000);
    rd(A_GCTL, 16'h0020, "R10 locked write ignored");

    step(2);
    finish_run();
  end

endmodule